// File: doc/BRIEF.md
# Byte-Serial GF(2^8) Column Mixer

This block applies the forward or the inverse column-mixing transform of the AES cipher to one four-byte column. It has no parallel multiplier. All arithmetic passes through a single 8-bit XOR path. An 8-bit working register holds the input byte as it is repeatedly doubled. A byte accumulator collects the partial products. A registered flag records the top bit of the working byte, and the control logic uses it to decide whether a doubling needs reduction.

A host pulses `start` with `inv_mode` set to the wanted direction. It then presents the four column bytes one at a time on `in_byte` with `in_valid`, row 0 first. Cycles with `in_valid` low may fall between the bytes. After the last byte is taken, the block builds each result byte from four coefficient products. Each product is formed by scanning the coefficient bits from the least significant bit upward. The block emits each result byte on its own `out_valid` cycle and then pulses `done`.

Top module: `gf_mixcol_serial`

## Requirements
- R1: After reset, `out_valid`, `done` and `busy` are all low.
- R2: In forward mode (`inv_mode` = 0 at start), result byte r is the GF(2^8) sum over j of c[(j-r) mod 4]·s[j], with c = {02, 03, 01, 01}. For example, column DB 13 53 45 gives 8E 4D A1 BC.
- R3: In inverse mode (`inv_mode` = 1 at start), the coefficient sequence is {0E, 0B, 0D, 09}. Feeding a forward result back through inverse mode restores the original column.
- R4: Multiplication is modulo x^8+x^4+x^3+x+1. Each doubling shifts left by one bit and XORs in 0x1B only when the bit shifted out was 1, so a column with 80 in row 0 yields 1B 80 80 9B.
- R5: Result bytes appear in row order 0, 1, 2, 3. Each is shown on `out_byte` with `out_valid` high for exactly one cycle. Row r is shown in the cycle after clock edge 36+37·r, counted from the edge that accepts the fourth input byte (edge 0).
- R6: `done` is high for exactly one cycle, after edge 148 counted the same way. `busy` is high from the edge after `start` through that cycle, and is low after it.
- R7: `start` while `busy` is high, and `in_valid` while the block is not collecting input bytes, have no effect on the result bytes or their timing.
- R8: Cycles with `in_valid` low between input bytes are skipped. The column is formed from the next four accepted bytes.
- R9: The direction is sampled only with an accepted `start`. Changing `inv_mode` during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| inv_mode | input | 1 | 0 forward transform, 1 inverse, sampled with start |
| in_valid | input | 1 | Qualifies in_byte while collecting the column |
| in_byte | input | 8 | Column byte, row 0 first |
| out_valid | output | 1 | One-cycle strobe per result byte |
| out_byte | output | 8 | Result byte, rows 0 to 3 in order |
| done | output | 1 | One-cycle pulse after the last result byte |
| busy | output | 1 | High while a run is in progress |

## Verification
Every result byte is due at a fixed edge counted from the acceptance of the fourth input byte: row r after edge 36+37·r, `done` after edge 148, and `busy` low after edge 149. The bench drives and samples on falling edges and counts edges from that acceptance. At each of the 149 following samples it checks that `out_valid` is high exactly at the four expected counts and carries the expected byte, and that `done` and `busy` change exactly at theirs. This means a late, early, repeated or reordered byte is reported even when its value is right. Runs that include input gaps, mid-run `start` pulses, stray `in_valid` and a toggled `inv_mode` use the same counting, so any disturbance of either timing or value is caught.

// File: rtl/gfmc_pkg.sv
package gfmc_pkg;

   localparam int GF_BYTE_W = 8;
   localparam logic [GF_BYTE_W-1:0] GF_REDUCE = 8'h1B;
   localparam logic [GF_BYTE_W-1:0] GF_PASS   = 8'h00;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_CALC,
      ST_EMIT,
      ST_DONE
   } gfmc_state_t;

endpackage

// File: rtl/gfmc_coef.sv
module gfmc_coef #(
   parameter int N_ROWS      = 4,
   parameter int COEF_W      = 4,
   parameter bit SUPPORT_INV = 1'b1,
   localparam int IDX_W      = $clog2(N_ROWS)
) (
   input  logic              inv,
   input  logic [IDX_W-1:0]  row,
   input  logic [IDX_W-1:0]  term,
   output logic [COEF_W-1:0] coef
);

   // column offset of this term relative to the diagonal, wrapping mod N_ROWS
   logic [IDX_W-1:0] offs;
   logic [COEF_W-1:0] fwd_c;
   assign offs = term - row;

   always_comb begin
      unique case (offs)
         2'd0:    fwd_c = COEF_W'(4'h2);
         2'd1:    fwd_c = COEF_W'(4'h3);
         default: fwd_c = COEF_W'(4'h1);
      endcase
   end

   generate
      if (SUPPORT_INV) begin : g_inv
         logic [COEF_W-1:0] inv_c;
         always_comb begin
            unique case (offs)
               2'd0:    inv_c = COEF_W'(4'hE);
               2'd1:    inv_c = COEF_W'(4'hB);
               2'd2:    inv_c = COEF_W'(4'hD);
               default: inv_c = COEF_W'(4'h9);
            endcase
         end
         assign coef = inv ? inv_c : fwd_c;
      end else begin : g_fwd_only
         logic unused_inv;
         assign unused_inv = inv;
         assign coef = fwd_c;
      end
   endgenerate

endmodule

// File: rtl/gfmc_ctrl.sv
module gfmc_ctrl
   import gfmc_pkg::*;
#(
   parameter int N_ROWS  = 4,
   parameter int COEF_W  = 4,
   localparam int IDX_W  = $clog2(N_ROWS),
   localparam int KB_W   = $clog2(COEF_W),
   localparam int STEPS  = 2 * COEF_W + 1,
   localparam int STEP_W = $clog2(STEPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              inv_mode,
   input  logic              in_valid,
   input  logic [COEF_W-1:0] coef,
   output logic              cap_en,
   output logic [IDX_W-1:0]  cap_idx,
   output logic              ld_work,
   output logic              acc_en,
   output logic              dbl_en,
   output logic              clr_acc,
   output logic [IDX_W-1:0]  row,
   output logic [IDX_W-1:0]  term,
   output logic              mode_q,
   output logic              out_valid,
   output logic              done,
   output logic              busy
);

   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(N_ROWS - 1);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
   localparam logic [KB_W:0]     ONE_K     = (KB_W+1)'(1);

   gfmc_state_t       state_q;
   logic [IDX_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  row_q;
   logic [IDX_W-1:0]  term_q;
   logic [STEP_W-1:0] step_q;
   logic [KB_W:0]     step_m1;
   logic [KB_W-1:0]   bit_idx;
   logic              phase_dbl;
   logic              in_calc;

   assign in_calc   = (state_q == ST_CALC);
   assign step_m1   = step_q[KB_W:0] - ONE_K;
   assign bit_idx   = step_m1[KB_W:1];
   assign phase_dbl = step_m1[0];

   assign cap_en    = (state_q == ST_LOAD) && in_valid;
   assign cap_idx   = cnt_q;
   assign ld_work   = in_calc && (step_q == '0);
   assign acc_en    = in_calc && (step_q != '0) && !phase_dbl && coef[bit_idx];
   assign dbl_en    = in_calc && (step_q != '0) && phase_dbl;
   assign clr_acc   = ((state_q == ST_IDLE) && start) || (state_q == ST_EMIT);
   assign row       = row_q;
   assign term      = term_q;
   assign out_valid = (state_q == ST_EMIT);
   assign done      = (state_q == ST_DONE);
   assign busy      = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         row_q   <= '0;
         term_q  <= '0;
         step_q  <= '0;
         mode_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_LOAD;
                  cnt_q   <= '0;
                  mode_q  <= inv_mode;
               end
            end
            ST_LOAD: begin
               if (in_valid) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == LAST_IDX) begin
                     state_q <= ST_CALC;
                     row_q   <= '0;
                     term_q  <= '0;
                     step_q  <= '0;
                  end
               end
            end
            ST_CALC: begin
               if (step_q == LAST_STEP) begin
                  step_q <= '0;
                  term_q <= term_q + 1'b1;
                  if (term_q == LAST_IDX) state_q <= ST_EMIT;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            ST_EMIT: begin
               if (row_q == LAST_IDX) begin
                  state_q <= ST_DONE;
               end else begin
                  row_q   <= row_q + 1'b1;
                  state_q <= ST_CALC;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R5
   out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R7
   restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> busy);

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (mode_q == $past(mode_q)));

endmodule

// File: rtl/gfmc_dp.sv
module gfmc_dp
   import gfmc_pkg::*;
#(
   parameter int N_ROWS  = 4,
   parameter int BYTE_W  = 8,
   localparam int IDX_W  = $clog2(N_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [IDX_W-1:0]  cap_idx,
   input  logic [BYTE_W-1:0] cap_byte,
   input  logic [IDX_W-1:0]  term,
   input  logic              ld_work,
   input  logic              acc_en,
   input  logic              dbl_en,
   input  logic              clr_acc,
   output logic [BYTE_W-1:0] acc
);

   logic [BYTE_W-1:0] col_q [N_ROWS];
   logic [BYTE_W-1:0] work_q;
   logic              msb_q;
   logic [BYTE_W-1:0] xa, xb, xr;

   // column buffer, one register per row
   generate
      for (genvar g = 0; g < N_ROWS; g++) begin : g_col
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   col_q[g] <= '0;
            else if (cap_en && (cap_idx == IDX_W'(g)))    col_q[g] <= cap_byte;
         end
      end
   endgenerate

   // the single shared XOR path
   always_comb begin
      if (dbl_en) begin
         xa = {work_q[BYTE_W-2:0], 1'b0};
         xb = msb_q ? GF_REDUCE : GF_PASS;
      end else if (acc_en) begin
         xa = acc;
         xb = work_q;
      end else begin
         xa = col_q[term];
         xb = GF_PASS;
      end
   end
   assign xr = xa ^ xb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q <= '0;
         msb_q  <= 1'b0;
         acc    <= '0;
      end else begin
         if (ld_work || dbl_en) begin
            work_q <= xr;
            msb_q  <= xr[BYTE_W-1];
         end
         if (clr_acc)     acc <= '0;
         else if (acc_en) acc <= xr;
      end
   end

   // R4
   reduce_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbl_en |=> (work_q[0] == $past(msb_q)));

   // R4
   double_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbl_en && !msb_q) |=> (work_q == {$past(work_q[BYTE_W-2:0]), 1'b0}));

endmodule

// File: rtl/gf_mixcol_serial.sv
module gf_mixcol_serial #(
   parameter int BYTE_W      = 8,
   parameter int N_ROWS      = 4,
   parameter int COEF_W      = 4,
   parameter bit SUPPORT_INV = 1'b1,
   localparam int IDX_W      = $clog2(N_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              inv_mode,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte,
   output logic              done,
   output logic              busy
);

   generate
      if (BYTE_W != gfmc_pkg::GF_BYTE_W) begin : g_bad_width
         $error("gf_mixcol_serial: BYTE_W must be 8");
      end
      if (N_ROWS != 4) begin : g_bad_rows
         $error("gf_mixcol_serial: N_ROWS must be 4");
      end
      if (COEF_W != 4) begin : g_bad_coef
         $error("gf_mixcol_serial: COEF_W must be 4");
      end
   endgenerate

   logic              cap_en, ld_work, acc_en, dbl_en, clr_acc, mode_q;
   logic [IDX_W-1:0]  cap_idx, row, term;
   logic [COEF_W-1:0] coef;

   gfmc_ctrl #(.N_ROWS(N_ROWS), .COEF_W(COEF_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .inv_mode  (inv_mode),
      .in_valid  (in_valid),
      .coef      (coef),
      .cap_en    (cap_en),
      .cap_idx   (cap_idx),
      .ld_work   (ld_work),
      .acc_en    (acc_en),
      .dbl_en    (dbl_en),
      .clr_acc   (clr_acc),
      .row       (row),
      .term      (term),
      .mode_q    (mode_q),
      .out_valid (out_valid),
      .done      (done),
      .busy      (busy)
   );

   gfmc_coef #(.N_ROWS(N_ROWS), .COEF_W(COEF_W), .SUPPORT_INV(SUPPORT_INV)) u_coef (
      .inv  (mode_q),
      .row  (row),
      .term (term),
      .coef (coef)
   );

   gfmc_dp #(.N_ROWS(N_ROWS), .BYTE_W(BYTE_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_idx  (cap_idx),
      .cap_byte (in_byte),
      .term     (term),
      .ld_work  (ld_work),
      .acc_en   (acc_en),
      .dbl_en   (dbl_en),
      .clr_acc  (clr_acc),
      .acc      (out_byte)
   );

   // R5
   out_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (!done && busy));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!out_valid && !done));

endmodule

// File: tb/tb_gf_mixcol_serial.sv
module tb_gf_mixcol_serial;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       inv_mode = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid, done, busy;
   logic [7:0] out_byte;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   gf_mixcol_serial dut (
      .clk(clk), .rst_n(rst_n), .start(start), .inv_mode(inv_mode),
      .in_valid(in_valid), .in_byte(in_byte), .out_valid(out_valid),
      .out_byte(out_byte), .done(done), .busy(busy)
   );

   // {input column, forward result}, row 0 in the top byte
   localparam logic [63:0] VEC [6] = '{
      {32'hDB135345, 32'h8E4DA1BC},
      {32'hF20A225C, 32'h9FDC589D},
      {32'h01010101, 32'h01010101},
      {32'hC6C6C6C6, 32'hC6C6C6C6},
      {32'hD4D4D4D5, 32'hD5D5D7D6},
      {32'h2D26314C, 32'h4D7EBDF8}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 8'h00;
      logic [7:0] x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p = p ^ x;
         x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
      end
      return p;
   endfunction

   function automatic logic [31:0] model(input logic [31:0] col, input logic inv);
      logic [7:0] c [4];
      logic [7:0] s [4];
      logic [31:0] r = '0;
      if (inv) begin c[0]=8'h0E; c[1]=8'h0B; c[2]=8'h0D; c[3]=8'h09; end
      else     begin c[0]=8'h02; c[1]=8'h03; c[2]=8'h01; c[3]=8'h01; end
      for (int j = 0; j < 4; j++) s[j] = col[31-8*j -: 8];
      for (int k = 0; k < 4; k++) begin
         logic [7:0] acc = 8'h00;
         for (int j = 0; j < 4; j++) acc = acc ^ gmul(c[(j - k + 4) % 4], s[j]);
         r[31-8*k -: 8] = acc;
      end
      return r;
   endfunction

   task automatic run(input logic [31:0] col, input logic inv, input int gap,
                      input bit poke, input logic [31:0] exp, input string req);
      @(negedge clk);
      start = 1'b1; inv_mode = inv;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         for (int g = 0; g < gap; g++) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_byte  = col[31-8*i -: 8];
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_byte  = 8'h00;
      for (int n = 1; n <= 149; n++) begin
         if (poke && n == 10) begin
            start = 1'b1; inv_mode = ~inv; in_valid = 1'b1; in_byte = 8'hA5;
         end
         if (poke && n == 12) begin
            start = 1'b0; in_valid = 1'b0;
         end
         @(negedge clk);
         if (n == 36 || n == 73 || n == 110 || n == 147) begin
            int r = (n - 36) / 37;
            chk(out_valid && out_byte == exp[31-8*r -: 8], {req, " R5 byte"},
                {23'd0, out_valid, out_byte}, {24'd1, exp[31-8*r -: 8]});
         end else if (out_valid) begin
            chk(1'b0, {req, " R5 stray out_valid"}, n, 0);
         end
         if (n == 148) chk(done && busy, {req, " R6 done"}, {done, busy}, 2'b11);
         else if (done) chk(1'b0, {req, " R6 stray done"}, n, 148);
         if (n == 149) chk(!busy, {req, " R6 busy low"}, busy, 0);
      end
      inv_mode = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(!out_valid && !done && !busy, "R1 reset", {out_valid, done, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && !done && !busy, "R1 after release", {out_valid, done, busy}, 0);

      // R2 forward table, R3 inverse restores, R8 gaps
      for (int v = 0; v < 6; v++) begin
         run(VEC[v][63:32], 1'b0, v % 3, 1'b0, VEC[v][31:0], "R2 fwd");
         run(VEC[v][31:0], 1'b1, (v + 1) % 3, 1'b0, VEC[v][63:32], "R3 inv");
      end

      // R4 reduction on top-bit bytes
      run(32'h80000000, 1'b0, 0, 1'b0, 32'h1B80809B, "R4 fwd 80");
      run(32'hFF80C001, 1'b1, 1, 1'b0, model(32'hFF80C001, 1'b1), "R4 inv mixed");

      // R7 stray in_valid while idle, then a normal run
      @(negedge clk);
      in_valid = 1'b1; in_byte = 8'h77;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk(!busy && !out_valid, "R7 idle in_valid", {busy, out_valid}, 0);
      run(32'h12345678, 1'b0, 0, 1'b0, model(32'h12345678, 1'b0), "R7 after stray");

      // R7 and R9: mid-run start, stray byte and flipped inv_mode
      run(32'hDB135345, 1'b0, 0, 1'b1, 32'h8E4DA1BC, "R9 poke fwd");
      run(32'h8E4DA1BC, 1'b1, 2, 1'b1, 32'hDB135345, "R9 poke inv");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule